// File: doc/BRIEF.md
# Three-Channel Match Timer with Selectable Reload

The block holds a set of independent up-counters that share one tick-enable input. Each channel compares its count against a small group of match values. A hit raises a sticky status flag for that comparator. Software chooses one comparator per channel through a reload selector. When the selected comparator hits, the counter is loaded from that channel's reload value instead of being incremented. Each channel drives one interrupt line, which is the OR of its status flags gated by a per-flag enable.

Software reaches the block over a simple synchronous word-addressed bus. Reads return data one cycle after the request. The counters cannot be read directly. Software writes a request to a capture register. The block then takes a copy of the channel 0 counter a fixed number of cycles later and holds it frozen until the next request. While the capture is pending, a busy flag is visible on a separate status word.

Top module: `tmr_match_timer`

Word address map, for the default of three channels and three comparators per channel:

| Address | Content |
|---|---|
| 0x00 to 0x08 | Match value, flat index 3*t+n for channel t, comparator n |
| 0x10+t | Reload value |
| 0x14+t | Reload selector |
| 0x18+t | Status |
| 0x1C+t | Interrupt enable |
| 0x20+t | Write-one-to-clear |
| 0x24 | Run bits, bit t for channel t |
| 0x25 | Capture request and captured value |
| 0x26 | Capture busy, bit 31 |

## Requirements
- R1: After a synchronous reset the following hold: every counter, reload value, selector, status, interrupt enable and run bit is 0; every match value is 0xFFFFFFFF; the captured value is 0, capture busy is 0 and all interrupt lines are low.
- R2: A channel's counter changes only on a cycle where `tick` is high and its run bit is set. The run bit for channel t is bit t of address 0x24.
- R3: The match value for comparator n of channel t sits at word address 3*t+n. Writing one match word changes no other match word.
- R4: On a counting cycle where the count equals match value n, status bit n of that channel is set. The status is read at address 0x18+t, with bit n belonging to comparator n. The flag stays set until software clears it.
- R5: With a reload selector value k from 1 to 3, a hit on comparator k-1 loads the reload value into the counter in place of the increment. Selector value 0 disables reload, and a hit then still increments.
- R6: The counter wraps from 0xFFFFFFFF to 0 in two cases: when selector 0 is in use, and when selector 1 is used with match 0 at 0xFFFFFFFF and a reload value of 0.
- R7: Writing a 1 to bit n of address 0x20+t clears status bit n of channel t. Bits written as 0 are left unchanged.
- R8: `irq[t]` is high when any status bit of channel t is set together with the matching bit of the interrupt enable at address 0x1C+t.
- R9: Writing a word with bit 0 set to address 0x25 sets capture busy (bit 31 of address 0x26) for 2 cycles. On the second edge after the request, the channel 0 count is copied. Reads of 0x25 then return that copy, and the copy stays frozen while counting continues.
- R10: A capture request written while busy is set is ignored and does not extend the busy time. A write to 0x25 with bit 0 clear starts no capture.
- R11: `rdata` is updated on the edge that samples `rd_en`. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle count enable shared by all channels |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 3 | Per-channel interrupt lines |

## Verification
The bench uses the default parameters: three channels of 32 bits, three comparators each, and a capture delay of 2 cycles. A 32-bit count cannot be stepped through in simulation. The wrap past 0xFFFFFFFF is therefore reached by reloading the counter to a value just below it, then changing the match and reload words. With a capture delay of 2, the exact cycle of each busy read can be checked, along with a second request placed inside the busy window.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_CH       = 3;
    localparam int TMR_NMATCH   = 3;
    localparam int TMR_W        = 32;
    localparam int TMR_AW       = 6;
    localparam int TMR_SNAP_DLY = 2;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_MATCH,
        RG_RELOAD,
        RG_SEL,
        RG_STATUS,
        RG_IE,
        RG_CLR,
        RG_RUN,
        RG_SNAP,
        RG_SNAP_ST
    } tmr_region_e;

    typedef struct packed {
        tmr_region_e rg;
        logic [3:0]  idx;
    } tmr_dec_t;

    // Word address decode; per-channel groups occupy four words each.
    function automatic tmr_dec_t tmr_decode(input logic [TMR_AW-1:0] a,
                                            input int n_match_regs,
                                            input int n_ch);
        tmr_dec_t d;
        d.rg  = RG_NONE;
        d.idx = a[3:0];
        if (int'(a) < n_match_regs) begin
            d.rg = RG_MATCH;
        end else begin
            d.idx = {2'b00, a[1:0]};
            case (a[5:2])
                4'h4: if (int'(a[1:0]) < n_ch) d.rg = RG_RELOAD;
                4'h5: if (int'(a[1:0]) < n_ch) d.rg = RG_SEL;
                4'h6: if (int'(a[1:0]) < n_ch) d.rg = RG_STATUS;
                4'h7: if (int'(a[1:0]) < n_ch) d.rg = RG_IE;
                4'h8: if (int'(a[1:0]) < n_ch) d.rg = RG_CLR;
                4'h9: begin
                    if (a[1:0] == 2'd0) d.rg = RG_RUN;
                    else if (a[1:0] == 2'd1) d.rg = RG_SNAP;
                    else if (a[1:0] == 2'd2) d.rg = RG_SNAP_ST;
                end
                default: d.rg = RG_NONE;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int W  = 32,
    parameter int NM = 3,
    localparam int CW = $clog2(NM + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 adv,
    input  logic [NM-1:0]        match_we,
    input  logic                 reload_we,
    input  logic                 sel_we,
    input  logic                 ie_we,
    input  logic                 clr_we,
    input  logic [W-1:0]         wdata,
    output logic [W-1:0]         cnt,
    output logic [NM-1:0][W-1:0] match_q,
    output logic [W-1:0]         reload_q,
    output logic [CW-1:0]        sel_q,
    output logic [NM-1:0]        status_q,
    output logic [NM-1:0]        ie_q,
    output logic                 irq
);

    logic [NM-1:0] hit;
    logic          reload_hit;

    for (genvar n = 0; n < NM; n++) begin : g_cmp
        assign hit[n] = adv && (cnt == match_q[n]);

        always_ff @(posedge clk) begin
            if (rst)              match_q[n] <= '1;
            else if (match_we[n]) match_q[n] <= wdata;
        end
    end

    always_comb begin
        reload_hit = 1'b0;
        for (int n = 0; n < NM; n++) begin
            if (sel_q == CW'(n + 1)) reload_hit = hit[n];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            reload_q <= '0;
            sel_q    <= '0;
            ie_q     <= '0;
            status_q <= '0;
        end else begin
            if (adv) cnt <= reload_hit ? reload_q : cnt + W'(1);
            if (reload_we) reload_q <= wdata;
            if (sel_we)    sel_q    <= wdata[CW-1:0];
            if (ie_we)     ie_q     <= wdata[NM-1:0];
            // a new hit wins over a clear in the same cycle
            status_q <= (status_q & ~(clr_we ? wdata[NM-1:0] : '0)) | hit;
        end
    end

    assign irq = |(status_q & ie_q);

endmodule

// File: rtl/tmr_snapshot.sv
module tmr_snapshot #(
    parameter int W   = 32,
    parameter int DLY = 2,
    localparam int DW = $clog2(DLY + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req,
    input  logic [W-1:0] src,
    output logic         busy,
    output logic [W-1:0] value
);

    logic [DW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
            value  <= '0;
        end else if (busy) begin
            if (remain == DW'(1)) begin
                value  <= src;
                busy   <= 1'b0;
                remain <= '0;
            end else begin
                remain <= remain - DW'(1);
            end
        end else if (req) begin
            busy   <= 1'b1;
            remain <= DW'(DLY);
        end
    end

endmodule

// File: rtl/tmr_match_timer.sv
module tmr_match_timer
    import tmr_pkg::*;
#(
    parameter int NUM_CH   = TMR_CH,
    parameter int NM       = TMR_NMATCH,
    parameter int W        = TMR_W,
    parameter int SNAP_DLY = TMR_SNAP_DLY,
    parameter int SNAP_CH  = 0,
    localparam int CW      = $clog2(NM + 1),
    localparam int NREGS   = NUM_CH * NM
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [TMR_AW-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    output logic [NUM_CH-1:0] irq
);

    tmr_dec_t dec;
    logic [NUM_CH-1:0]                 en_q;
    logic [NUM_CH-1:0][W-1:0]          ch_cnt;
    logic [NUM_CH-1:0][NM-1:0][W-1:0]  ch_match;
    logic [NUM_CH-1:0][W-1:0]          ch_reload;
    logic [NUM_CH-1:0][CW-1:0]         ch_sel;
    logic [NUM_CH-1:0][NM-1:0]         ch_status;
    logic [NUM_CH-1:0][NM-1:0]         ch_ie;
    logic                              snap_busy;
    logic [W-1:0]                      snap_val;
    logic [W-1:0]                      rd_mux;

    assign dec = tmr_decode(addr, NREGS, NUM_CH);

    for (genvar t = 0; t < NUM_CH; t++) begin : g_ch
        logic [NM-1:0] m_we;
        logic          here;

        assign here = (dec.idx == 4'(t)) && wr_en;
        for (genvar n = 0; n < NM; n++) begin : g_mwe
            assign m_we[n] = wr_en && (dec.rg == RG_MATCH) && (dec.idx == 4'(t * NM + n));
        end

        tmr_channel #(.W(W), .NM(NM)) i_chan (
            .clk       (clk),
            .rst       (rst),
            .adv       (tick && en_q[t]),
            .match_we  (m_we),
            .reload_we (here && dec.rg == RG_RELOAD),
            .sel_we    (here && dec.rg == RG_SEL),
            .ie_we     (here && dec.rg == RG_IE),
            .clr_we    (here && dec.rg == RG_CLR),
            .wdata     (wdata),
            .cnt       (ch_cnt[t]),
            .match_q   (ch_match[t]),
            .reload_q  (ch_reload[t]),
            .sel_q     (ch_sel[t]),
            .status_q  (ch_status[t]),
            .ie_q      (ch_ie[t]),
            .irq       (irq[t])
        );
    end

    tmr_snapshot #(.W(W), .DLY(SNAP_DLY)) i_snap (
        .clk   (clk),
        .rst   (rst),
        .req   (wr_en && dec.rg == RG_SNAP && wdata[0]),
        .src   (ch_cnt[SNAP_CH]),
        .busy  (snap_busy),
        .value (snap_val)
    );

    always_ff @(posedge clk) begin
        if (rst)                          en_q <= '0;
        else if (wr_en && dec.rg == RG_RUN) en_q <= wdata[NUM_CH-1:0];
    end

    always_comb begin
        rd_mux = '0;
        case (dec.rg)
            RG_MATCH: begin
                for (int i = 0; i < NREGS; i++) begin
                    if (dec.idx == 4'(i)) rd_mux = ch_match[i / NM][i % NM];
                end
            end
            RG_RELOAD, RG_SEL, RG_STATUS, RG_IE: begin
                for (int t = 0; t < NUM_CH; t++) begin
                    if (dec.idx == 4'(t)) begin
                        if (dec.rg == RG_RELOAD)      rd_mux = ch_reload[t];
                        else if (dec.rg == RG_SEL)    rd_mux[CW-1:0] = ch_sel[t];
                        else if (dec.rg == RG_STATUS) rd_mux[NM-1:0] = ch_status[t];
                        else                          rd_mux[NM-1:0] = ch_ie[t];
                    end
                end
            end
            RG_RUN:     rd_mux[NUM_CH-1:0] = en_q;
            RG_SNAP:    rd_mux = snap_val;
            RG_SNAP_ST: rd_mux[W-1] = snap_busy;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

endmodule

// File: rtl/tmr_match_timer_chk.sv
module tmr_match_timer_chk #(
    parameter int NUM_CH   = 3,
    parameter int NM       = 3,
    parameter int W        = 32,
    parameter int SNAP_DLY = 2,
    localparam int CW      = $clog2(NM + 1),
    localparam int BW      = $clog2(SNAP_DLY + 2)
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             tick,
    input logic [NUM_CH-1:0]                en_q,
    input logic [NUM_CH-1:0][W-1:0]         ch_cnt,
    input logic [NUM_CH-1:0][NM-1:0][W-1:0] ch_match,
    input logic [NUM_CH-1:0][W-1:0]         ch_reload,
    input logic [NUM_CH-1:0][CW-1:0]        ch_sel,
    input logic [NUM_CH-1:0][NM-1:0]        ch_status,
    input logic                             snap_busy
);

    logic [BW-1:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst)            busy_len <= '0;
        else if (snap_busy) busy_len <= busy_len + BW'(1);
        else                busy_len <= '0;
    end

    for (genvar t = 0; t < NUM_CH; t++) begin : g_ch
        assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
            !(tick && en_q[t]) |=> $stable(ch_cnt[t]));

        assert_step_R6: assert property (@(posedge clk) disable iff (rst)
            (tick && en_q[t] && ch_sel[t] == '0) |=> ch_cnt[t] == $past(ch_cnt[t]) + W'(1));

        for (genvar n = 0; n < NM; n++) begin : g_cmp
            assert_flag_R4: assert property (@(posedge clk) disable iff (rst)
                (tick && en_q[t] && ch_cnt[t] == ch_match[t][n]) |=> ch_status[t][n]);

            assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
                (tick && en_q[t] && ch_sel[t] == CW'(n + 1) && ch_cnt[t] == ch_match[t][n])
                |=> ch_cnt[t] == $past(ch_reload[t]));
        end
    end

    assert_busy_bound_R10: assert property (@(posedge clk) disable iff (rst)
        snap_busy |-> busy_len < BW'(SNAP_DLY));

    assert_busy_len_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(snap_busy) |-> busy_len == BW'(SNAP_DLY));

endmodule

bind tmr_match_timer tmr_match_timer_chk #(
    .NUM_CH(NUM_CH), .NM(NM), .W(W), .SNAP_DLY(SNAP_DLY)
) i_tmr_match_timer_chk (.*);

// File: tb/test_tmr_match_timer.sv
module test_tmr_match_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tmr_match_timer i_tmr_match_timer (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic snap(output logic [31:0] v);
        wr(6'h25, 32'h1);
        repeat (2) @(negedge clk);
        rd(6'h25, v);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(6'h00, v); chk("R1 match0", v, 32'hFFFF_FFFF);
        rd(6'h08, v); chk("R1 match8", v, 32'hFFFF_FFFF);
        rd(6'h18, v); chk("R1 status", v, 32'h0);
        rd(6'h24, v); chk("R1 run", v, 32'h0);
        rd(6'h26, v); chk("R1 busy", v, 32'h0);
        rd(6'h25, v); chk("R1 capture", v, 32'h0);
        chk("R1 irq", {29'b0, irq}, 32'h0);
    endtask

    task automatic t_map;
        logic [31:0] v;
        wr(6'h05, 32'h55);
        rd(6'h05, v); chk("R3 flat 5", v, 32'h55);
        rd(6'h04, v); chk("R3 flat 4 untouched", v, 32'hFFFF_FFFF);
        rd(6'h06, v); chk("R3 flat 6 untouched", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_count;
        logic [31:0] v;
        wr(6'h24, 32'h1);
        ticks(5);
        repeat (3) @(negedge clk);
        snap(v); chk("R2 five ticks", v, 32'd5);
        wr(6'h24, 32'h0);
        ticks(3);
        snap(v); chk("R2 disabled hold", v, 32'd5);
        wr(6'h24, 32'h1);
    endtask

    task automatic t_match_irq;
        logic [31:0] v;
        wr(6'h01, 32'd7);
        ticks(2);
        rd(6'h18, v); chk("R4 no hit yet", v, 32'h0);
        ticks(1);
        rd(6'h18, v); chk("R4 comparator 1 flag", v, 32'h2);
        chk("R8 masked", {31'b0, irq[0]}, 32'h0);
        wr(6'h1C, 32'h2);
        chk("R8 enabled", {31'b0, irq[0]}, 32'h1);
        wr(6'h1C, 32'h1);
        chk("R8 other enable", {31'b0, irq[0]}, 32'h0);
        wr(6'h20, 32'h1);
        rd(6'h18, v); chk("R7 zero bit kept", v, 32'h2);
        wr(6'h20, 32'h2);
        rd(6'h18, v); chk("R7 cleared", v, 32'h0);
        wr(6'h1C, 32'h2);
        chk("R8 after clear", {31'b0, irq[0]}, 32'h0);
    endtask

    task automatic t_reload;
        logic [31:0] v;
        wr(6'h00, 32'd10); wr(6'h10, 32'h100); wr(6'h14, 32'h1);
        ticks(3);
        snap(v); chk("R5 sel 1 reload", v, 32'h100);
        rd(6'h18, v); chk("R4 comparator 0 flag", v, 32'h1);
        wr(6'h01, 32'h102); wr(6'h10, 32'h20); wr(6'h14, 32'h2);
        ticks(3);
        snap(v); chk("R5 sel 2 reload", v, 32'h20);
        wr(6'h01, 32'h22); wr(6'h14, 32'h0);
        ticks(3);
        snap(v); chk("R5 sel 0 no reload", v, 32'h23);
        rd(6'h18, v); chk("R5 flag without reload", v, 32'h3);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        wr(6'h00, 32'h25); wr(6'h10, 32'hFFFF_FFFE); wr(6'h14, 32'h1);
        ticks(3);
        snap(v); chk("R6 near top", v, 32'hFFFF_FFFE);
        wr(6'h00, 32'hFFFF_FFFF); wr(6'h10, 32'h0);
        ticks(1);
        snap(v); chk("R6 top", v, 32'hFFFF_FFFF);
        ticks(1);
        snap(v); chk("R6 reload wrap", v, 32'h0);
        wr(6'h00, 32'h0); wr(6'h10, 32'hFFFF_FFFF);
        ticks(1);
        wr(6'h14, 32'h0);
        ticks(1);
        snap(v); chk("R6 natural wrap", v, 32'h0);
    endtask

    task automatic t_capture;
        logic [31:0] v;
        ticks(4);
        wr(6'h25, 32'h1);
        rd(6'h26, v); chk("R9 busy edge 1", v, 32'h8000_0000);
        rd(6'h26, v); chk("R9 busy edge 2", v, 32'h8000_0000);
        rd(6'h26, v); chk("R9 busy done", v, 32'h0);
        rd(6'h25, v); chk("R9 captured", v, 32'd4);
        ticks(3);
        rd(6'h25, v); chk("R9 frozen", v, 32'd4);
        wr(6'h25, 32'h0);
        rd(6'h26, v); chk("R10 bit0 clear", v, 32'h0);
        wr(6'h25, 32'h1);
        wr(6'h25, 32'h1);
        rd(6'h26, v); chk("R10 busy", v, 32'h8000_0000);
        rd(6'h26, v); chk("R10 not extended", v, 32'h0);
        rd(6'h25, v); chk("R10 value", v, 32'd7);
    endtask

    task automatic t_chan1;
        logic [31:0] v;
        wr(6'h03, 32'd2); wr(6'h1D, 32'h1); wr(6'h24, 32'h3);
        ticks(2);
        chk("R8 ch1 before hit", {31'b0, irq[1]}, 32'h0);
        ticks(1);
        chk("R8 ch1 hit", {31'b0, irq[1]}, 32'h1);
        rd(6'h19, v); chk("R4 ch1 status", v, 32'h1);
        rd(6'h3F, v); chk("R11 unmapped 3F", v, 32'h0);
        rd(6'h27, v); chk("R11 unmapped 27", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_map;
        t_count;
        t_match_irq;
        t_reload;
        t_wrap;
        t_capture;
        t_chan1;
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule